// File: doc/BRIEF.md
# Memory Playback Read Sequencer

This block streams stored sample words out of external memory toward a transmit link. Software writes one 32-bit control word that holds a start bit, a loop bit, a stop bit, a transceiver-mode bit and a length field. The block then walks a word address from zero upward, one burst of eight words at a time. For each burst it raises read enables toward one or two memory banks. It puts each returned word onto a 256-bit output that carries a valid flag.

In the normal mode both banks are read at the same address, and each supplies 128 bits of every output word. In transceiver mode only the second bank is read, and it supplies the full 256 bits. Playback stops once the address reaches the length field, or it wraps back to zero and repeats when loop is set. Stop forces the block back to idle. While idle, the last output word stays on the output.

Top module: `playback_sequencer`

## Requirements
- R1: The control word fields are: bit 0 start, bit 1 loop, bit 2 stop, bit 3 transceiver mode, bits 31:4 length in words. The length equals a quarter of the samples per channel.
- R2: After reset the block is idle, both read enables are low, `streamValid` is low and `streamData` is zero.
- R3: A 0-to-1 change of the start bit while idle begins playback at address 0. A start bit held high does not begin a second playback.
- R4: A read request is issued only when `memReady` and `dsReady` are both high. Both banks get the same address. Requests run 0, 8, 16 and so on, one burst of 8 words per request.
- R5: Without loop, the request at address a with a+8 >= length is the last one, and the block then returns to idle. The burst count is max(1, ceil(length/8)), so length 16384 (65536 samples per channel) gives 2048 requests.
- R6: With loop, after the last burst the address returns to 0 and playback continues without end.
- R7: While stop is set no request is issued, and stop wins over a start edge. The address resets, so the next playback begins at address 0.
- R8: In any cycle after one in which no read data arrives, `streamValid` is low and `streamData` keeps its previous value.
- R9: In normal mode both enables are asserted together. Output bits 127:0 come from bank A data and bits 255:128 come from bits 127:0 of the bank B data.
- R10: In transceiver mode the bank A enable is never asserted, and the output word is the full 256-bit bank B data.
- R11: Output is registered. Read data arriving in one cycle appears with `streamValid` high in the next cycle. Arrival means both valids in normal mode and only the bank B valid in transceiver mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWord | input | 32 | Control word from software |
| memReady | input | 1 | Memory can take a read request |
| dsReady | input | 1 | Downstream link can take data |
| bankARdEn | output | 1 | Read request to bank A |
| bankAAddr | output | 28 | Word address for bank A |
| bankARdValid | input | 1 | Bank A read data valid |
| bankARdData | input | 128 | Bank A read data |
| bankBRdEn | output | 1 | Read request to bank B |
| bankBAddr | output | 28 | Word address for bank B |
| bankBRdValid | input | 1 | Bank B read data valid |
| bankBRdData | input | 256 | Bank B read data (low half used in normal mode) |
| streamData | output | 256 | Output word |
| streamValid | output | 1 | Output word valid |

## Verification
The assertions assume that memory returns read data only after a request and, in normal mode, raises both bank valids in the same cycle. They also assume that the mode bit does not change while read data is still in flight. The bench memory model meets these assumptions. It lowers `memReady` for the whole burst it is serving and returns both halves in lockstep. The bench changes the mode or the control word only after the scoreboard queue has drained and the memory model has gone quiet.

// File: rtl/pb_pkg.sv
package pb_pkg;
  localparam int CTRL_W  = 32;
  localparam int LEN_LSB = 4;
  localparam int LEN_W   = CTRL_W - LEN_LSB;

  typedef enum logic {
    PB_IDLE   = 1'b0,
    PB_STREAM = 1'b1
  } pbState_t;

  typedef struct packed {
    logic             startRise;
    logic             loopEn;
    logic             stopReq;
    logic             xcvrMode;
    logic [LEN_W-1:0] len;
  } pbCmd_t;

  typedef struct packed {
    logic capture;
    logic xcvrSel;
  } pbStrobe_t;
endpackage

// File: rtl/pb_cmd_decode.sv
module pb_cmd_decode
  import pb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CTRL_W-1:0] ctrlWord,
  output pbCmd_t            cmd
);
  logic startPrev;

  always_ff @(posedge clk) begin
    if (!rstN) startPrev <= 1'b0;
    else       startPrev <= ctrlWord[0];
  end

  always_comb begin
    cmd.startRise = ctrlWord[0] & ~startPrev;
    cmd.loopEn    = ctrlWord[1];
    cmd.stopReq   = ctrlWord[2];
    cmd.xcvrMode  = ctrlWord[3];
    cmd.len       = ctrlWord[CTRL_W-1:LEN_LSB];
  end
endmodule

// File: rtl/pb_ctrl.sv
module pb_ctrl
  import pb_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int BURST  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pbCmd_t            cmd,
  input  logic              memReady,
  input  logic              dsReady,
  input  logic              aValid,
  input  logic              bValid,
  output logic              aRdEn,
  output logic              bRdEn,
  output logic [ADDR_W-1:0] rdAddr,
  output pbStrobe_t         strobe
);
  localparam int CMP_W = ((ADDR_W > LEN_W) ? ADDR_W : LEN_W) + 1;

  pbState_t          state;
  logic [ADDR_W-1:0] addrCnt;
  logic              issue;
  logic              lastBurst;
  logic [CMP_W-1:0]  addrEnd;

  always_comb begin
    addrEnd   = CMP_W'(addrCnt) + CMP_W'(BURST);
    lastBurst = addrEnd >= CMP_W'(cmd.len);
    issue     = (state == PB_STREAM) && memReady && dsReady && !cmd.stopReq;
    aRdEn     = issue && !cmd.xcvrMode;
    bRdEn     = issue;
    rdAddr    = addrCnt;
    strobe.xcvrSel = cmd.xcvrMode;
    strobe.capture = cmd.xcvrMode ? bValid : (aValid & bValid);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= PB_IDLE;
      addrCnt <= '0;
    end else begin
      unique case (state)
        PB_IDLE: begin
          addrCnt <= '0;
          if (cmd.startRise && !cmd.stopReq) state <= PB_STREAM;
        end
        PB_STREAM: begin
          if (cmd.stopReq) begin
            state   <= PB_IDLE;
            addrCnt <= '0;
          end else if (issue) begin
            if (lastBurst) begin
              addrCnt <= '0;
              if (!cmd.loopEn) state <= PB_IDLE;
            end else begin
              addrCnt <= addrCnt + ADDR_W'(BURST);
            end
          end
        end
        default: state <= PB_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pb_datapath.sv
module pb_datapath
  import pb_pkg::*;
#(
  parameter int WORD_W = 256,
  parameter int HALF_W = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  pbStrobe_t         strobe,
  input  logic [HALF_W-1:0] aData,
  input  logic [WORD_W-1:0] bData,
  output logic [WORD_W-1:0] streamData,
  output logic              streamValid
);
  logic [WORD_W-1:0] merged;

  generate
    if (WORD_W == 2 * HALF_W) begin : g_even
      always_comb merged = strobe.xcvrSel ? bData : {bData[HALF_W-1:0], aData};
    end else begin : g_pad
      always_comb merged = strobe.xcvrSel ? bData
                          : WORD_W'({bData[HALF_W-1:0], aData});
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      streamData  <= '0;
      streamValid <= 1'b0;
    end else begin
      streamValid <= strobe.capture;
      if (strobe.capture) streamData <= merged;
    end
  end
endmodule

// File: rtl/playback_sequencer.sv
module playback_sequencer
  import pb_pkg::*;
#(
  parameter int WORD_W = 256,
  parameter int ADDR_W = 28,
  parameter int BURST  = 8,
  localparam int HALF_W = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       ctrlWord,
  input  logic              memReady,
  input  logic              dsReady,
  output logic              bankARdEn,
  output logic [ADDR_W-1:0] bankAAddr,
  input  logic              bankARdValid,
  input  logic [HALF_W-1:0] bankARdData,
  output logic              bankBRdEn,
  output logic [ADDR_W-1:0] bankBAddr,
  input  logic              bankBRdValid,
  input  logic [WORD_W-1:0] bankBRdData,
  output logic [WORD_W-1:0] streamData,
  output logic              streamValid
);
  pbCmd_t            cmd;
  pbStrobe_t         strobe;
  logic [ADDR_W-1:0] rdAddr;

  pb_cmd_decode u_dec (
    .clk(clk), .rstN(rstN), .ctrlWord(ctrlWord), .cmd(cmd)
  );

  pb_ctrl #(.ADDR_W(ADDR_W), .BURST(BURST)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmd(cmd), .memReady(memReady), .dsReady(dsReady),
    .aValid(bankARdValid), .bValid(bankBRdValid),
    .aRdEn(bankARdEn), .bRdEn(bankBRdEn), .rdAddr(rdAddr), .strobe(strobe)
  );

  pb_datapath #(.WORD_W(WORD_W), .HALF_W(HALF_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .aData(bankARdData), .bData(bankBRdData),
    .streamData(streamData), .streamValid(streamValid)
  );

  assign bankAAddr = rdAddr;
  assign bankBAddr = rdAddr;
endmodule

// File: rtl/pb_checker.sv
module pb_checker #(
  parameter int WORD_W = 256,
  parameter int ADDR_W = 28,
  parameter int BURST  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [31:0]       ctrlWord,
  input logic              memReady,
  input logic              dsReady,
  input logic              bankARdEn,
  input logic [ADDR_W-1:0] bankAAddr,
  input logic              bankARdValid,
  input logic              bankBRdEn,
  input logic [ADDR_W-1:0] bankBAddr,
  input logic              bankBRdValid,
  input logic [WORD_W-1:0] streamData,
  input logic              streamValid
);
  logic arrived;
  assign arrived = ctrlWord[3] ? bankBRdValid : (bankARdValid && bankBRdValid);

  // R4
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    bankBRdEn |-> (memReady && dsReady));

  // R4
  addr_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    bankBRdEn |-> ((bankBAddr % BURST) == 0 && bankAAddr == bankBAddr));

  // R7
  stop_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWord[2] |-> !bankBRdEn);

  // R9
  pair_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWord[3] |-> (bankARdEn == bankBRdEn));

  // R10
  xcvr_no_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWord[3] |-> !bankARdEn);

  // R8
  hold_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    !arrived |=> (!streamValid && $stable(streamData)));

  // R11
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    arrived |=> streamValid);
endmodule

bind playback_sequencer pb_checker #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .BURST(BURST)) u_chk (
  .clk(clk), .rstN(rstN), .ctrlWord(ctrlWord), .memReady(memReady), .dsReady(dsReady),
  .bankARdEn(bankARdEn), .bankAAddr(bankAAddr), .bankARdValid(bankARdValid),
  .bankBRdEn(bankBRdEn), .bankBAddr(bankBAddr), .bankBRdValid(bankBRdValid),
  .streamData(streamData), .streamValid(streamValid)
);

// File: tb/playback_sequencer_bench.sv
`timescale 1ns/1ps
module playback_sequencer_bench;
  localparam int WORD_W = 256;
  localparam int HALF_W = 128;
  localparam int ADDR_W = 28;
  localparam int BURST  = 8;
  localparam int LAT    = 3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [31:0]       ctrlWord = '0;
  logic              memReady;
  logic              dsReady = 1'b1;
  logic              bankARdEn, bankBRdEn;
  logic [ADDR_W-1:0] bankAAddr, bankBAddr;
  logic              bankARdValid, bankBRdValid;
  logic [HALF_W-1:0] bankARdData;
  logic [WORD_W-1:0] bankBRdData;
  logic [WORD_W-1:0] streamData;
  logic              streamValid;

  int total = 0;
  int bad = 0;
  int reqCount = 0;
  int aEnSeen = 0;
  int popped = 0;
  logic memAllow = 1'b1;
  logic [WORD_W-1:0] lastWord = '0;
  logic [WORD_W-1:0] expQ[$];

  always #2.5 clk = ~clk;

  playback_sequencer u_playback_sequencer (
    .clk(clk), .rstN(rstN), .ctrlWord(ctrlWord), .memReady(memReady), .dsReady(dsReady),
    .bankARdEn(bankARdEn), .bankAAddr(bankAAddr), .bankARdValid(bankARdValid),
    .bankARdData(bankARdData), .bankBRdEn(bankBRdEn), .bankBAddr(bankBAddr),
    .bankBRdValid(bankBRdValid), .bankBRdData(bankBRdData),
    .streamData(streamData), .streamValid(streamValid)
  );

  function automatic logic [HALF_W-1:0] fA(input logic [31:0] x);
    return {4{x ^ 32'h1111_0000}};
  endfunction

  function automatic logic [WORD_W-1:0] fB(input logic [31:0] x);
    return {x ^ 32'h8000_0000, ~x, x + 32'd7, x ^ 32'h5,
            x * 32'd3, x, ~(x + 32'd1), x ^ 32'h00FF_00FF};
  endfunction

  task automatic chkInt(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // memory model: one burst at a time, memReady low while serving
  int ph;
  logic [ADDR_W-1:0] base;
  logic useA;
  always @(posedge clk) begin
    if (!rstN) begin
      ph <= 0; memReady <= 1'b0; bankARdValid <= 1'b0; bankBRdValid <= 1'b0;
      bankARdData <= '0; bankBRdData <= '0; base <= '0; useA <= 1'b0;
    end else begin
      bankARdValid <= 1'b0;
      bankBRdValid <= 1'b0;
      if (bankARdEn) aEnSeen++;
      if (bankBRdEn) begin
        reqCount++;
        // R9 R10 both banks share one address, A enable follows mode
        chkInt("R9 addr match", int'(bankAAddr == bankBAddr), 1);
        chkInt("R10 A enable vs mode", int'(bankARdEn), int'(!ctrlWord[3]));
        chkInt("R4 request while busy", ph, 0);
      end
      if (ph == 0) begin
        if (bankBRdEn) begin
          base <= bankBAddr; useA <= bankARdEn; ph <= 1; memReady <= 1'b0;
        end else memReady <= memAllow;
      end else begin
        if (ph > LAT) begin
          logic [31:0] x;
          x = {{(32-ADDR_W){1'b0}}, base} + 32'(ph - LAT - 1);
          bankBRdData  <= fB(x);
          bankARdData  <= fA(x);
          bankBRdValid <= 1'b1;
          bankARdValid <= useA;
        end
        ph <= (ph == LAT + BURST) ? 0 : ph + 1;
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && streamValid) begin
      total++;
      if (expQ.size() == 0) begin
        bad++;
        $display("FAIL R5/R11 unexpected word: actual=%h expected=none", streamData);
      end else begin
        logic [WORD_W-1:0] e;
        e = expQ.pop_front();
        popped++;
        if (streamData !== e) begin
          bad++;
          $display("FAIL R9/R10/R4 data: actual=%h expected=%h", streamData, e);
        end
      end
      lastWord = streamData;
    end
  end

  task automatic expectRun(input bit xcvr, input int len, input int passes);
    int nb;
    nb = (len == 0) ? 1 : (len + BURST - 1) / BURST;
    for (int p = 0; p < passes; p++)
      for (int b = 0; b < nb; b++)
        for (int k = 0; k < BURST; k++) begin
          logic [31:0] x;
          logic [WORD_W-1:0] w;
          x = 32'(b * BURST + k);
          w = fB(x);
          if (xcvr) expQ.push_back(w);
          else      expQ.push_back({w[HALF_W-1:0], fA(x)});
        end
  endtask

  task automatic setCtrl(input bit st, input bit lp, input bit sp, input bit xc, input int len);
    @(negedge clk);
    ctrlWord = {28'(len), xc, sp, lp, st};
  endtask

  task automatic waitDrain(input string tag, input int limit);
    int n = 0;
    while (expQ.size() != 0 && n < limit) begin @(negedge clk); n++; end
    repeat (20) @(negedge clk);
    chkInt(tag, expQ.size(), 0);
  endtask

  initial begin
    int rc;
    int p0;
    repeat (4) @(negedge clk);
    // R2 reset state
    chkInt("R2 valid", int'(streamValid), 0);
    chkInt("R2 data", int'(streamData == '0), 1);
    chkInt("R2 enables", int'(bankARdEn | bankBRdEn), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chkInt("R2 idle no request", reqCount, 0);

    // R1 R5 R9 normal run, length 20 -> 3 bursts
    expectRun(1'b0, 20, 1);
    rc = reqCount;
    setCtrl(1, 0, 0, 0, 20);
    waitDrain("R5 len20 drain", 500);
    chkInt("R5 len20 bursts", reqCount - rc, 3);
    // R3 start held high gives no second run
    repeat (30) @(negedge clk);
    chkInt("R3 held start", reqCount - rc, 3);
    // R8 hold after stop of traffic
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chkInt("R8 valid low", int'(streamValid), 0);
      chkInt("R8 data held", int'(streamData == lastWord), 1);
    end

    // R10 transceiver mode with memory first unavailable (R4)
    setCtrl(0, 0, 0, 1, 16);
    memAllow = 1'b0;
    repeat (3) @(negedge clk);
    aEnSeen = 0;
    expectRun(1'b1, 16, 1);
    rc = reqCount;
    setCtrl(1, 0, 0, 1, 16);
    repeat (30) @(negedge clk);
    chkInt("R4 memReady low blocks", reqCount - rc, 0);
    memAllow = 1'b1;
    waitDrain("R10 xcvr drain", 500);
    chkInt("R10 bursts", reqCount - rc, 2);
    chkInt("R10 bank A unused", aEnSeen, 0);

    // R5 zero length gives one burst
    setCtrl(0, 0, 0, 0, 0);
    expectRun(1'b0, 0, 1);
    rc = reqCount;
    setCtrl(1, 0, 0, 0, 0);
    waitDrain("R5 len0 drain", 300);
    chkInt("R5 len0 bursts", reqCount - rc, 1);

    // R6 loop wraps; dsReady gating (R4)
    setCtrl(0, 1, 0, 0, 24);
    expectRun(1'b0, 24, 5);
    p0 = popped;
    setCtrl(1, 1, 0, 0, 24);
    begin
      int n = 0;
      while (expQ.size() > 48 && n < 3000) begin @(negedge clk); n++; end
    end
    dsReady = 1'b0;
    repeat (40) @(negedge clk);
    rc = reqCount;
    repeat (20) @(negedge clk);
    chkInt("R4 dsReady low blocks", reqCount - rc, 0);
    chkInt("R6 wrapped past one pass", int'(popped - p0 >= 72), 1);
    // R7 stop forces idle
    setCtrl(1, 1, 1, 0, 24);
    expQ.delete();
    dsReady = 1'b1;
    repeat (20) @(negedge clk);
    chkInt("R7 stop idles", reqCount - rc, 0);
    // R7 stop wins over start edge
    setCtrl(0, 0, 1, 0, 8);
    setCtrl(1, 0, 1, 0, 8);
    repeat (20) @(negedge clk);
    chkInt("R7 stop over start", reqCount - rc, 0);
    setCtrl(1, 0, 0, 0, 8);
    repeat (20) @(negedge clk);
    chkInt("R3 no edge no start", reqCount - rc, 0);
    // R7 restart begins at address 0
    setCtrl(0, 0, 0, 0, 8);
    expectRun(1'b0, 8, 1);
    setCtrl(1, 0, 0, 0, 8);
    waitDrain("R7 restart at zero", 300);
    chkInt("R7 restart bursts", reqCount - rc, 1);

    // R1 R5 length 16384 (65536 samples per channel) -> 2048 bursts
    setCtrl(0, 0, 0, 0, 16384);
    expectRun(1'b0, 16384, 1);
    rc = reqCount;
    setCtrl(1, 0, 0, 0, 16384);
    waitDrain("R5 long drain", 60000);
    chkInt("R1 R5 long bursts", reqCount - rc, 2048);
    // R11 last output stays after run
    chkInt("R11 final data", int'(streamData == lastWord), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule